// File: doc/BRIEF.md
# Serially Addressed 8-Bit I/O Port Expander

This block is a serial slave that gives a host an 8-bit general-purpose port over a four-wire SPI-style link. Each pin can act as an input or an output, under the control of its bit in a direction register. A data register supplies the values on the output pins. A compare control register picks one of four pin-versus-register conditions. The result of that condition is a flag, and the block returns the flag to the host in every transfer, so the host never needs a separate read to get it.

A transfer is two bytes while chip select is low. The first byte is a command: two device-address bits, which must match the two strap inputs, then a register select, a read/write bit and a write mode (load, set bits or clear bits). While the command byte shifts in, a status byte shifts out. The second byte carries write data toward the block, or read data from it. The link inputs are oversampled by the system clock through synchronizers. The level of SCK when chip select goes low fixes the clock polarity for that transfer.

Top module: `spi_port_expander`

## Requirements
- R1: After reset, `pin_oe` and `pin_out` are zero, `miso_oe` is low and the compare control register reads back zero.
- R2: `pin_oe` equals the direction register and `pin_out` equals the data register; a direction bit of 1 makes that pin an output.
- R3: The command byte is `[7:6]` address, `[5:4]` select (0 data, 1 direction, 2 compare control, 3 none), `[3]` read when 1, `[2:1]` write mode, `[0]` ignored. A command whose address differs from `strap` changes no register and leaves `miso_oe` low.
- R4: The SCK level seen when `cs_n` falls is the idle level. MOSI is sampled on the first edge away from it and MISO changes on the return edge, so both idle levels work. Bits travel MSB first.
- R5: Write mode 0 or 3 loads the byte, mode 1 ORs it into the register and mode 2 clears the register bits that are 1 in the byte. Modes apply to every writable register.
- R6: The compare control bits `[1:0]` select the flag condition: 0 all synchronized pins equal the data register; 1 any pin differs; 2 all input pins (direction 0) equal; 3 any input pin differs.
- R7: During the command byte, MISO carries the status byte `{2'b00, flag, 5'b00000}`, with the flag as the third bit out. `miso_oe` rises once both address bits have matched.
- R8: A read returns the selected register in the second byte. Reading data returns the data register on output pins and the synchronized pin level on input pins.
- R9: A register is written only after all 16 bits have arrived; raising `cs_n` earlier changes nothing.
- R10: Select 3 writes nothing and reads back zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Drive enable for MISO |
| strap | input | 2 | Device address straps |
| pin_in | input | 8 | Port pin levels |
| pin_out | output | 8 | Port output values |
| pin_oe | output | 8 | Port output enables |

## Verification
Random commands with random pin levels, direction masks and polarity test the write modes against each other, because set, clear and load of the same byte leave different results. They also test all four compare conditions, since masked and unmasked conditions only disagree when an output pin differs from its data bit. Directed transfers use a foreign address, a chip select raised after 12 bits, the unused select and the high-idle clock. These separate a block that really ignores such traffic from one that writes anyway.

// File: rtl/spi_pe_pkg.sv
package spi_pe_pkg;
  localparam int PORT_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int XFER_LEN = 2 * PORT_W;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DDR  = 2'd1,
    SEL_CMP  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    WM_LOAD  = 2'd0,
    WM_SET   = 2'd1,
    WM_CLR   = 2'd2,
    WM_LOADB = 2'd3
  } wmode_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    sel_e              sel;
    logic              rd;
    wmode_e            mode;
    logic              spare;
  } cmd_t;
endpackage

// File: rtl/spi_pe_sync.sv
module spi_pe_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_pe_link.sv
module spi_pe_link
  import spi_pe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [ADDR_W-1:0] strap,
  input  logic              cmp_flag,
  input  logic [PORT_W-1:0] rd_data,
  output sel_e              rd_sel,
  output logic              miso,
  output logic              miso_oe,
  output logic              wr_stb,
  output sel_e              wr_sel,
  output wmode_e            wr_mode,
  output logic [PORT_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(XFER_LEN + 1);

  logic             active, cpol, sck_prev, addr_ok;
  logic [CNT_W-1:0] cnt;
  logic [PORT_W-1:0] in_sh, out_sh, nxt, status;
  cmd_t             cmd;
  logic             lead, trail;

  assign nxt    = {in_sh[PORT_W-2:0], mosi_s};
  assign lead   = (sck_s != sck_prev) && (sck_s != cpol);
  assign trail  = (sck_s != sck_prev) && (sck_s == cpol);
  assign status = {2'b00, cmp_flag, 5'b00000};

  always_ff @(posedge clk) begin
    sck_prev <= sck_s;
    wr_stb   <= 1'b0;
    if (rst) begin
      active  <= 1'b0;
      cpol    <= 1'b0;
      cnt     <= '0;
      in_sh   <= '0;
      out_sh  <= '0;
      addr_ok <= 1'b0;
      cmd     <= '0;
      wr_data <= '0;
    end else if (cs_n_s) begin
      active  <= 1'b0;
      cnt     <= '0;
      addr_ok <= 1'b0;
    end else if (!active) begin
      active <= 1'b1;
      cpol   <= sck_s;
      cnt    <= '0;
      out_sh <= status;
    end else begin
      if (lead && cnt < CNT_W'(XFER_LEN)) begin
        in_sh <= nxt;
        cnt   <= cnt + 1'b1;
        if (cnt == CNT_W'(ADDR_W - 1)) addr_ok <= (nxt[ADDR_W-1:0] == strap);
        if (cnt == CNT_W'(PORT_W - 1)) cmd <= cmd_t'(nxt);
        if (cnt == CNT_W'(XFER_LEN - 1) && addr_ok && !cmd.rd) begin
          wr_stb  <= 1'b1;
          wr_data <= nxt;
        end
      end
      if (trail) begin
        if (cnt == CNT_W'(PORT_W)) out_sh <= rd_data;
        else out_sh <= {out_sh[PORT_W-2:0], 1'b0};
      end
    end
  end

  assign rd_sel  = cmd.sel;
  assign wr_sel  = cmd.sel;
  assign wr_mode = cmd.mode;
  assign miso    = out_sh[PORT_W-1];
  assign miso_oe = addr_ok;

  // R3: drive enable drops after chip select goes away
  assert_oe_drops_R3: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !miso_oe);
  // R3: writes only for a matching address
  assert_wr_match_R3: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> addr_ok);
  // R4: captured polarity holds for the whole transfer
  assert_cpol_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> $stable(cpol));
  // R9: a write only follows the full 16 bits
  assert_full_xfer_R9: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (cnt == CNT_W'(XFER_LEN)));
endmodule

// File: rtl/spi_pe_regs.sv
module spi_pe_regs
  import spi_pe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] pin_s,
  input  logic              wr_stb,
  input  sel_e              wr_sel,
  input  wmode_e            wr_mode,
  input  logic [PORT_W-1:0] wr_data,
  input  sel_e              rd_sel,
  output logic [PORT_W-1:0] rd_data,
  output logic              cmp_flag,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  logic [PORT_W-1:0] data_q, ddr_q, cmp_q;
  logic              eq_all, eq_in, flag_d;

  function automatic logic [PORT_W-1:0] apply_wr(input logic [PORT_W-1:0] old_v,
                                                 input logic [PORT_W-1:0] new_v,
                                                 input wmode_e m);
    case (m)
      WM_SET:  return old_v | new_v;
      WM_CLR:  return old_v & ~new_v;
      default: return new_v;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      ddr_q  <= '0;
      cmp_q  <= '0;
    end else if (wr_stb) begin
      case (wr_sel)
        SEL_DATA: data_q <= apply_wr(data_q, wr_data, wr_mode);
        SEL_DDR:  ddr_q  <= apply_wr(ddr_q,  wr_data, wr_mode);
        SEL_CMP:  cmp_q  <= apply_wr(cmp_q,  wr_data, wr_mode);
        default: ;
      endcase
    end
  end

  assign eq_all = (pin_s == data_q);
  assign eq_in  = (((pin_s ^ data_q) & ~ddr_q) == '0);

  always_comb begin
    case (cmp_q[1:0])
      2'd0:    flag_d = eq_all;
      2'd1:    flag_d = !eq_all;
      2'd2:    flag_d = eq_in;
      default: flag_d = !eq_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cmp_flag <= 1'b0;
    else cmp_flag <= flag_d;
  end

  always_comb begin
    case (rd_sel)
      SEL_DATA: rd_data = (ddr_q & data_q) | (~ddr_q & pin_s);
      SEL_DDR:  rd_data = ddr_q;
      SEL_CMP:  rd_data = cmp_q;
      default:  rd_data = '0;
    endcase
  end

  assign pin_out = data_q;
  assign pin_oe  = ddr_q;

  // R1: port comes out of reset as all inputs driving zero
  assert_reset_in_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0 && pin_out == '0));
  // R9: registers hold without a write strobe
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> ($stable(data_q) && $stable(ddr_q) && $stable(cmp_q)));
  // R5: bit-set leaves every written 1 set
  assert_set_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_sel == SEL_DATA && wr_mode == WM_SET) |=>
      ((data_q & $past(wr_data)) == $past(wr_data)));
  // R5: bit-clear leaves every written 1 cleared
  assert_clr_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_sel == SEL_DATA && wr_mode == WM_CLR) |=>
      ((data_q & $past(wr_data)) == '0));
endmodule

// File: rtl/spi_port_expander.sv
module spi_port_expander
  import spi_pe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic [ADDR_W-1:0] strap,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  logic [2:0]        link_s;
  logic [PORT_W-1:0] pin_s, rd_data, wr_data;
  logic              cmp_flag, wr_stb;
  sel_e              rd_sel, wr_sel;
  wmode_e            wr_mode;

  spi_pe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_link_sync (
    .clk(clk), .rst(rst), .d({mosi, cs_n, sck}), .q(link_s));

  spi_pe_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s));

  spi_pe_link u_link (
    .clk(clk), .rst(rst), .sck_s(link_s[0]), .cs_n_s(link_s[1]), .mosi_s(link_s[2]),
    .strap(strap), .cmp_flag(cmp_flag), .rd_data(rd_data), .rd_sel(rd_sel),
    .miso(miso), .miso_oe(miso_oe), .wr_stb(wr_stb), .wr_sel(wr_sel),
    .wr_mode(wr_mode), .wr_data(wr_data));

  spi_pe_regs u_regs (
    .clk(clk), .rst(rst), .pin_s(pin_s), .wr_stb(wr_stb), .wr_sel(wr_sel),
    .wr_mode(wr_mode), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .cmp_flag(cmp_flag), .pin_out(pin_out), .pin_oe(pin_oe));
endmodule

// File: tb/spi_port_expander_tb.sv
module spi_port_expander_tb;
  logic       clk = 0, rst = 1, sck = 0, cs_n = 1, mosi = 0;
  logic       miso, miso_oe;
  logic [1:0] strap = 2'b10;
  logic [7:0] pin_in = 8'h00, pin_out, pin_oe;
  int checks = 0, errors = 0;
  logic [7:0] mdata = 0, mddr = 0, mcmp = 0;
  logic [15:0] rx;
  bit oe_last, oe_any;

  always #5 clk = ~clk;

  spi_port_expander u_dut (.clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .strap(strap), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic chk(input bit ok, input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic bit exp_flag();
    logic [7:0] df = pin_in ^ mdata;
    case (mcmp[1:0])
      2'd0: return df == 0;
      2'd1: return df != 0;
      2'd2: return (df & ~mddr) == 0;
      default: return (df & ~mddr) != 0;
    endcase
  endfunction

  function automatic logic [7:0] apply(input logic [7:0] o, input logic [7:0] n, input logic [1:0] m);
    case (m)
      2'd1: return o | n;
      2'd2: return o & ~n;
      default: return n;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] sel);
    case (sel)
      2'd0: return (mddr & mdata) | (~mddr & pin_in);
      2'd1: return mddr;
      2'd2: return mcmp;
      default: return 8'h00;
    endcase
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] d, input int nbits, input bit pol);
    logic [15:0] word = {c, d};
    rx = 0; oe_last = 0; oe_any = 0;
    sck = pol; wclk(4);
    cs_n = 0; wclk(8);
    for (int i = 0; i < nbits; i++) begin
      mosi = word[15-i];
      wclk(8);
      rx[15-i] = miso;
      oe_last = miso_oe;
      oe_any |= miso_oe;
      sck = ~pol; wclk(8);
      sck = pol;
    end
    wclk(8); cs_n = 1; wclk(8);
  endtask

  // full transfer with model update and checks
  task automatic op(input logic [7:0] c, input logic [7:0] d, input bit pol, input string req);
    bit match = (c[7:6] == strap);
    bit rd = c[3];
    logic [7:0] es = {2'b00, exp_flag(), 5'b0};
    logic [7:0] er = exp_read(c[5:4]);
    xfer(c, d, 16, pol);
    if (match) begin
      chk(rx[15:8] == es, {req, " R7 status"}, {8'h0, rx[15:8]}, {8'h0, es});
      chk(oe_last, {req, " R7 oe"}, {15'h0, oe_last}, 16'h1);
      if (rd) chk(rx[7:0] == er, {req, " R8 read"}, {8'h0, rx[7:0]}, {8'h0, er});
      else case (c[5:4])
        2'd0: mdata = apply(mdata, d, c[2:1]);
        2'd1: mddr  = apply(mddr, d, c[2:1]);
        2'd2: mcmp  = apply(mcmp, d, c[2:1]);
        default: ;
      endcase
    end else begin
      chk(!oe_any, {req, " R3 oe"}, {15'h0, oe_any}, 16'h0);
    end
    chk(pin_out == mdata, {req, " R2 pin_out"}, {8'h0, pin_out}, {8'h0, mdata});
    chk(pin_oe == mddr, {req, " R2 pin_oe"}, {8'h0, pin_oe}, {8'h0, mddr});
  endtask

  function automatic logic [7:0] cmd(input logic [1:0] a, input logic [1:0] s, input bit r, input logic [1:0] m);
    return {a, s, r, m, 1'b0};
  endfunction

  initial begin
    fork
      begin
        wclk(199000);
        chk(0, "watchdog", 16'h0, 16'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    void'($urandom(32'd2024));
    wclk(4); rst = 0; wclk(4);
    // R1 reset state
    chk(pin_oe == 0 && pin_out == 0, "R1 port", {pin_oe, pin_out}, 16'h0);
    chk(!miso_oe, "R1 miso_oe", {15'h0, miso_oe}, 16'h0);
    op(cmd(strap, 2, 1, 0), 8'h00, 0, "R1 cmp read");
    // R5 write modes
    op(cmd(strap, 0, 0, 0), 8'hA5, 0, "R5 load");
    op(cmd(strap, 0, 0, 1), 8'h0F, 0, "R5 set");
    chk(pin_out == 8'hAF, "R5 set value", {8'h0, pin_out}, 16'h00AF);
    op(cmd(strap, 0, 0, 2), 8'hA0, 0, "R5 clr");
    chk(pin_out == 8'h0F, "R5 clr value", {8'h0, pin_out}, 16'h000F);
    op(cmd(strap, 1, 0, 3), 8'hF0, 0, "R2 ddr load");
    // R4 high idle clock
    op(cmd(strap, 1, 1, 0), 8'h00, 1, "R4 pol1 read");
    op(cmd(strap, 0, 0, 0), 8'h3C, 1, "R4 pol1 write");
    // R3 foreign address
    op(cmd(~strap, 0, 0, 0), 8'hFF, 0, "R3 foreign write");
    op(cmd(~strap, 1, 0, 1), 8'hFF, 1, "R3 foreign ddr");
    // R9 abort after 12 bits
    xfer(cmd(strap, 0, 0, 0), 8'h99, 12, 0);
    chk(pin_out == mdata, "R9 abort", {8'h0, pin_out}, {8'h0, mdata});
    op(cmd(strap, 0, 1, 0), 8'h00, 0, "R9 abort read");
    // R10 unused select
    op(cmd(strap, 3, 0, 0), 8'h77, 0, "R10 write");
    op(cmd(strap, 3, 1, 0), 8'h00, 0, "R10 read");
    // R6 each compare condition
    for (int k = 0; k < 4; k++) begin
      op(cmd(strap, 2, 0, 0), 8'(k), 0, "R6 cond");
      pin_in = mdata; wclk(6);
      op(cmd(strap, 0, 1, 0), 8'h00, 0, "R6 equal");
      pin_in = mdata ^ 8'h80; wclk(6);
      op(cmd(strap, 0, 1, 0), 8'h00, 0, "R6 out differs");
      pin_in = mdata ^ 8'h01; wclk(6);
      op(cmd(strap, 0, 1, 0), 8'h00, 1, "R6 in differs");
    end
    // random mix
    for (int n = 0; n < 200; n++) begin
      logic [1:0] a = ($urandom % 4 == 0) ? ~strap : strap;
      pin_in = 8'($urandom); wclk(4);
      op(cmd(a, 2'($urandom), 1'($urandom), 2'($urandom)), 8'($urandom), 1'($urandom), "R5 R6 random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule